// File: doc/BRIEF.md
# Link-Side Transceiver Bus Controller (8-bit, synchronous mode)

This block sits on the link side of an 8-bit transceiver bus that runs in synchronous mode. All bus signals are timed by one 60 MHz interface clock. The bus has one shared byte-wide data path. The transceiver (the PHY) drives a direction input that decides who owns that path. It also drives a next/accept input. The controller drives a single stop output. The data path is brought out as separate input, output and output-enable pins, so that the pad ring can build the bidirectional pin.

On the user side there is a small request port. It takes register writes, register reads and packet transmits. The controller turns each request into a nonzero command byte on the bus. It holds that byte until the PHY accepts it, then finishes the transfer. When the PHY takes the bus, the controller releases the data path at once. It ignores the one turnaround cycle that follows each direction change. After that, it reports each byte either as a receive-status byte, as received packet data, or as the answer to a pending register read.

Top module: `ulpi_link_ctrl`

## Requirements
- R1: While `rst` is high and `ulpi_dir_i` is low, the link enables its output with `ulpi_data_o` = 0, `ulpi_stp_o` = 0 and every valid strobe low. In the first cycle after reset release, `req_ready_o` is high.
- R2: When the link owns the bus and has no transfer in progress, it drives `ulpi_data_o` = 8'h00 with the output enabled and `ulpi_stp_o` low.
- R3: `ulpi_data_oe_o` is low in any cycle in which `ulpi_dir_i` is high. It stays low for the turnaround cycle after `ulpi_dir_i` falls, which ends at the first rising edge that samples the low level.
- R4: The cycle after a request is accepted, the link drives a command byte and holds it until `ulpi_nxt_i` is sampled high while it owns the bus. For `req_kind_i` = 0 (register write) the byte is {2'b10, addr[5:0]}. For kind 1 (register read) it is {2'b11, addr[5:0]}. For kind 2 (packet transmit) it is {2'b01, 2'b00, addr[3:0]}, with addr[3:0] used as the packet identifier.
- R5: For a register write, the cycle after acceptance on `ulpi_nxt_i` carries `req_wdata_i`. The next cycle has `ulpi_stp_o` high with data 0, and the cycle after that is idle. `ulpi_stp_o` is never high for two cycles in a row.
- R6: For a packet transmit, the cycle after acceptance on `ulpi_nxt_i` has `ulpi_stp_o` high with data 0, and the link then returns to idle.
- R7: For a register read, after acceptance the link waits for `ulpi_dir_i` to rise and skips the turnaround cycle. It then captures the next byte and shows it on `rsp_data_o` with a one-cycle `rsp_valid_o` pulse in the cycle that follows. That byte is not reported as status.
- R8: If `ulpi_dir_i` rises while a command byte waits for acceptance, the command is abandoned without completing. It is driven again in the first owned cycle after the bus returns.
- R9: With `ulpi_dir_i` high past the turnaround, `ulpi_nxt_i` low and no read pending, the sampled byte appears on `stat_data_o` with a one-cycle `stat_valid_o` pulse in the next cycle.
- R10: With `ulpi_dir_i` high past the turnaround and `ulpi_nxt_i` high, the byte appears on `rx_data_o` with a one-cycle `rx_valid_o` pulse in the next cycle. `rx_valid_o` and `stat_valid_o` are never high together.
- R11: A byte present during a turnaround edge (either direction) is never reported on any of the three result outputs.
- R12: `req_ready_o` is high only when the link is idle and owns the bus. A request is taken when `req_valid_i` and `req_ready_o` are both high at a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz interface clock |
| rst | input | 1 | Synchronous active-high reset |
| ulpi_data_i | input | 8 | Data bus as seen at the pad |
| ulpi_data_o | output | 8 | Data the link drives |
| ulpi_data_oe_o | output | 1 | Output enable for the data pads |
| ulpi_dir_i | input | 1 | Bus direction from the PHY (high: PHY drives) |
| ulpi_nxt_i | input | 1 | PHY accept / data-qualifier strobe |
| ulpi_stp_o | output | 1 | Stop strobe ending a link transfer |
| req_valid_i | input | 1 | User request present |
| req_kind_i | input | 2 | 0 write, 1 read, 2 transmit |
| req_addr_i | input | 6 | Register address, or identifier in bits [3:0] |
| req_wdata_i | input | 8 | Register write data |
| req_ready_o | output | 1 | Request accepted at this edge if valid |
| rsp_valid_o | output | 1 | Register read result strobe |
| rsp_data_o | output | 8 | Register read result |
| stat_valid_o | output | 1 | Receive-status byte strobe |
| stat_data_o | output | 8 | Receive-status byte |
| rx_valid_o | output | 1 | Received data byte strobe |
| rx_data_o | output | 8 | Received data byte |

## Verification
The output enable reacts to `ulpi_dir_i` within the same cycle on a rise. On a fall it returns one edge later. Both cases are checked in the cycle, and a negedge monitor covers every cycle of the run. The command byte is due one edge after acceptance. The write data byte, the stop pulse and the return to idle each follow one edge after the one before. The read, status and receive results show up one edge after the edge that sampled the byte. The bench changes inputs 2 time units after each rising edge and samples 1 unit later, so every check sees the state left by exactly the edge that the requirement counts from.

// File: rtl/ulpi_link_pkg.sv
package ulpi_link_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 6;
    localparam int PID_W  = 4;
    localparam int KIND_W = 2;
    localparam int OP_W   = DATA_W - ADDR_W;

    typedef enum logic [KIND_W-1:0] {
        KIND_WRITE = 2'd0,
        KIND_READ  = 2'd1,
        KIND_XMIT  = 2'd2
    } req_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WDATA,
        ST_STOP,
        ST_RD_WAIT,
        ST_RD_DONE
    } link_state_e;

    typedef struct packed {
        req_kind_e             kind;
        logic [ADDR_W-1:0]     addr;
        logic [DATA_W-1:0]     wdata;
    } link_req_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } byte_evt_t;

    localparam logic [OP_W-1:0] OP_XMIT = 2'b01;
    localparam logic [OP_W-1:0] OP_REGW = 2'b10;
    localparam logic [OP_W-1:0] OP_REGR = 2'b11;

    function automatic logic [DATA_W-1:0] make_txcmd(link_req_t r);
        logic [DATA_W-1:0] b;
        case (r.kind)
            KIND_READ: b = {OP_REGR, r.addr};
            KIND_XMIT: b = {OP_XMIT, {(ADDR_W-PID_W){1'b0}}, r.addr[PID_W-1:0]};
            default:   b = {OP_REGW, r.addr};
        endcase
        return b;
    endfunction

endpackage

// File: rtl/ulpi_turn_track.sv
module ulpi_turn_track (
    input  logic clk,
    input  logic rst,
    input  logic dir_i,
    output logic own_o,
    output logic turn_o,
    output logic listen_o
);
    logic dir_q;

    always_ff @(posedge clk) begin
        if (rst) dir_q <= 1'b0;
        else     dir_q <= dir_i;
    end

    assign own_o    = !dir_i && !dir_q;
    assign turn_o   = dir_i ^ dir_q;
    assign listen_o = dir_i && dir_q;

    p_listen_after_turn_r11: assert property (@(posedge clk) disable iff (rst)
        listen_o |-> $past(dir_i));

endmodule

// File: rtl/ulpi_link_fsm.sv
module ulpi_link_fsm
    import ulpi_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              own_i,
    input  logic              listen_i,
    input  logic              dir_i,
    input  logic              nxt_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              req_valid_i,
    input  link_req_t         req_i,
    output logic              req_ready_o,
    output logic [DATA_W-1:0] data_o,
    output logic              stp_o,
    output logic              reading_o,
    output byte_evt_t         rsp_o
);
    link_state_e state;
    link_req_t   cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cur   <= '0;
            rsp_o <= '0;
        end else begin
            rsp_o.valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (own_i && req_valid_i) begin
                        cur   <= req_i;
                        state <= ST_CMD;
                    end
                end
                ST_CMD: begin
                    if (own_i && nxt_i) begin
                        case (cur.kind)
                            KIND_READ: state <= ST_RD_WAIT;
                            KIND_XMIT: state <= ST_STOP;
                            default:   state <= ST_WDATA;
                        endcase
                    end
                end
                ST_WDATA: state <= ST_STOP;
                ST_STOP:  state <= ST_IDLE;
                ST_RD_WAIT: begin
                    if (listen_i) begin
                        rsp_o.valid <= 1'b1;
                        rsp_o.data  <= data_i;
                        state       <= ST_RD_DONE;
                    end
                end
                ST_RD_DONE: begin
                    if (!dir_i) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_CMD:   data_o = make_txcmd(cur);
            ST_WDATA: data_o = cur.wdata;
            default:  data_o = '0;
        endcase
    end

    assign req_ready_o = (state == ST_IDLE) && own_i;
    assign stp_o       = (state == ST_STOP);
    assign reading_o   = (state == ST_RD_WAIT);

    p_stp_single_r5: assert property (@(posedge clk) disable iff (rst)
        stp_o |=> !stp_o);

    p_cmd_held_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CMD && !(own_i && nxt_i)) |=> (state == ST_CMD && $stable(data_o)));

    p_rsp_single_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_o.valid |=> !rsp_o.valid);

    p_ready_owner_r12: assert property (@(posedge clk) disable iff (rst)
        req_ready_o |-> !dir_i);

endmodule

// File: rtl/ulpi_rx_sniff.sv
module ulpi_rx_sniff
    import ulpi_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              listen_i,
    input  logic              reading_i,
    input  logic              nxt_i,
    input  logic [DATA_W-1:0] data_i,
    output byte_evt_t         stat_o,
    output byte_evt_t         rxd_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_o <= '0;
            rxd_o  <= '0;
        end else begin
            stat_o.valid <= 1'b0;
            rxd_o.valid  <= 1'b0;
            if (listen_i && !reading_i) begin
                if (nxt_i) begin
                    rxd_o.valid <= 1'b1;
                    rxd_o.data  <= data_i;
                end else begin
                    stat_o.valid <= 1'b1;
                    stat_o.data  <= data_i;
                end
            end
        end
    end

    p_evt_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(stat_o.valid && rxd_o.valid));

    p_stat_after_listen_r9: assert property (@(posedge clk) disable iff (rst)
        stat_o.valid |-> $past(listen_i) && !$past(nxt_i));

endmodule

// File: rtl/ulpi_link_ctrl.sv
module ulpi_link_ctrl
    import ulpi_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] ulpi_data_i,
    output logic [DATA_W-1:0] ulpi_data_o,
    output logic              ulpi_data_oe_o,
    input  logic              ulpi_dir_i,
    input  logic              ulpi_nxt_i,
    output logic              ulpi_stp_o,
    input  logic              req_valid_i,
    input  logic [KIND_W-1:0] req_kind_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              req_ready_o,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_data_o,
    output logic              stat_valid_o,
    output logic [DATA_W-1:0] stat_data_o,
    output logic              rx_valid_o,
    output logic [DATA_W-1:0] rx_data_o
);
    logic      own, turn, listen, reading;
    link_req_t req;
    byte_evt_t rsp, stat, rxd;

    assign req.kind  = req_kind_e'(req_kind_i);
    assign req.addr  = req_addr_i;
    assign req.wdata = req_wdata_i;

    ulpi_turn_track u_turn (
        .clk      (clk),
        .rst      (rst),
        .dir_i    (ulpi_dir_i),
        .own_o    (own),
        .turn_o   (turn),
        .listen_o (listen)
    );

    ulpi_link_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .own_i       (own),
        .listen_i    (listen),
        .dir_i       (ulpi_dir_i),
        .nxt_i       (ulpi_nxt_i),
        .data_i      (ulpi_data_i),
        .req_valid_i (req_valid_i),
        .req_i       (req),
        .req_ready_o (req_ready_o),
        .data_o      (ulpi_data_o),
        .stp_o       (ulpi_stp_o),
        .reading_o   (reading),
        .rsp_o       (rsp)
    );

    ulpi_rx_sniff u_sniff (
        .clk       (clk),
        .rst       (rst),
        .listen_i  (listen),
        .reading_i (reading),
        .nxt_i     (ulpi_nxt_i),
        .data_i    (ulpi_data_i),
        .stat_o    (stat),
        .rxd_o     (rxd)
    );

    assign ulpi_data_oe_o = own;
    assign rsp_valid_o    = rsp.valid;
    assign rsp_data_o     = rsp.data;
    assign stat_valid_o   = stat.valid;
    assign stat_data_o    = stat.data;
    assign rx_valid_o     = rxd.valid;
    assign rx_data_o      = rxd.data;

    p_release_r3: assert property (@(posedge clk) disable iff (rst)
        ulpi_dir_i |-> !ulpi_data_oe_o);

    p_no_result_on_turn_r11: assert property (@(posedge clk) disable iff (rst)
        turn |=> !(stat_valid_o || rx_valid_o || rsp_valid_o));

endmodule

// File: tb/tb_ulpi_link_ctrl.sv
module tb_ulpi_link_ctrl;
    localparam int CLK_PERIOD = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] data_in;
    logic [7:0] data_out;
    logic       oe;
    logic       dir;
    logic       nxt;
    logic       stp;
    logic       req_valid;
    logic [1:0] req_kind;
    logic [5:0] req_addr;
    logic [7:0] req_wdata;
    logic       req_ready;
    logic       rsp_valid;
    logic [7:0] rsp_data;
    logic       stat_valid;
    logic [7:0] stat_data;
    logic       rx_valid;
    logic [7:0] rx_data;

    int checks = 0;
    int fails = 0;
    int bus_viol = 0;
    logic dir_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ulpi_link_ctrl dut (
        .clk(clk), .rst(rst),
        .ulpi_data_i(data_in), .ulpi_data_o(data_out), .ulpi_data_oe_o(oe),
        .ulpi_dir_i(dir), .ulpi_nxt_i(nxt), .ulpi_stp_o(stp),
        .req_valid_i(req_valid), .req_kind_i(req_kind), .req_addr_i(req_addr),
        .req_wdata_i(req_wdata), .req_ready_o(req_ready),
        .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
        .stat_valid_o(stat_valid), .stat_data_o(stat_data),
        .rx_valid_o(rx_valid), .rx_data_o(rx_data)
    );

    // R3: link must never drive while the PHY drives or during the turnaround after a fall
    always @(posedge clk) dir_seen <= dir;
    always @(negedge clk) if (!rst && (dir || dir_seen) && oe) bus_viol++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_cmd(input logic [1:0] kind, input logic [5:0] addr);
        case (kind)
            2'd1:    return {2'b11, addr};
            2'd2:    return {2'b01, 2'b00, addr[3:0]};
            default: return {2'b10, addr};
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic issue(input logic [1:0] kind, input logic [5:0] addr, input logic [7:0] wd);
        req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = wd;
        #1 chk(req_ready === 1'b1, "R12 ready in idle", req_ready, 1);
        tick();
        req_valid = 1'b0;
        #1 chk(oe && data_out === exp_cmd(kind, addr), "R4 command byte", data_out, exp_cmd(kind, addr));
        chk(req_ready === 1'b0, "R12 busy not ready", req_ready, 0);
    endtask

    task automatic hold_cmd(input logic [7:0] expc, input int n);
        for (int i = 0; i < n; i++) begin
            tick();
            #1 chk(data_out === expc, "R4 command held", data_out, expc);
        end
    endtask

    task automatic back_idle();
        #1 chk(oe && data_out === 8'h00 && !stp && req_ready, "R2 idle zeros", {oe, stp, data_out}, {2'b10, 8'h00});
    endtask

    task automatic do_write(input logic [5:0] addr, input logic [7:0] wd, input int hold);
        issue(2'd0, addr, wd);
        hold_cmd(exp_cmd(2'd0, addr), hold);
        nxt = 1'b1; tick(); nxt = 1'b0;
        #1 chk(oe && data_out === wd && !stp, "R5 write data", data_out, wd);
        tick();
        #1 chk(stp && data_out === 8'h00, "R5 stop after data", {stp, data_out}, {1'b1, 8'h00});
        tick();
        back_idle();
    endtask

    task automatic do_xmit(input logic [5:0] addr, input int hold);
        issue(2'd2, addr, 8'h00);
        hold_cmd(exp_cmd(2'd2, addr), hold);
        nxt = 1'b1; tick(); nxt = 1'b0;
        #1 chk(stp && data_out === 8'h00, "R6 transmit stop", {stp, data_out}, {1'b1, 8'h00});
        tick();
        back_idle();
    endtask

    task automatic do_read(input logic [5:0] addr, input logic [7:0] rd, input int hold, input logic [7:0] junk);
        issue(2'd1, addr, 8'h00);
        hold_cmd(exp_cmd(2'd1, addr), hold);
        nxt = 1'b1; tick(); nxt = 1'b0;
        dir = 1'b1; data_in = junk;
        #1 chk(!oe, "R3 release on rise", oe, 0);
        tick();
        #1 chk(!stat_valid && !rx_valid && !rsp_valid, "R11 turnaround ignored (read)", {stat_valid, rx_valid, rsp_valid}, 0);
        data_in = rd;
        tick();
        #1 chk(rsp_valid && rsp_data === rd, "R7 read data", rsp_data, rd);
        chk(!stat_valid && !rx_valid, "R7 read byte not status", {stat_valid, rx_valid}, 0);
        dir = 1'b0; data_in = 8'h00;
        #1 chk(!oe && !req_ready, "R3 turnaround after fall", {oe, req_ready}, 0);
        tick();
        #1 chk(!rsp_valid, "R7 single pulse", rsp_valid, 0);
        back_idle();
    endtask

    task automatic rx_burst(input int n);
        dir = 1'b1; nxt = 1'($urandom_range(0, 1)); data_in = 8'(($urandom_range(1, 255)));
        #1 chk(!oe, "R3 release on rise", oe, 0);
        tick();
        #1 chk(!stat_valid && !rx_valid, "R11 turnaround ignored (rise)", {stat_valid, rx_valid}, 0);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            logic       q;
            b = 8'($urandom_range(0, 255));
            q = 1'($urandom_range(0, 1));
            data_in = b; nxt = q;
            tick();
            if (q) begin
                #1 chk(rx_valid && !stat_valid && rx_data === b, "R10 receive byte", rx_data, b);
            end else begin
                #1 chk(stat_valid && !rx_valid && stat_data === b, "R9 status byte", stat_data, b);
            end
        end
        dir = 1'b0; nxt = 1'b0; data_in = 8'h5A;
        #1 chk(!oe, "R3 turnaround after fall", oe, 0);
        tick();
        #1 chk(!stat_valid && !rx_valid, "R11 turnaround ignored (fall)", {stat_valid, rx_valid}, 0);
        data_in = 8'h00;
        back_idle();
    endtask

    task automatic do_abort(input logic [5:0] addr, input logic [7:0] wd, input logic [7:0] sb);
        logic [7:0] c;
        c = exp_cmd(2'd0, addr);
        issue(2'd0, addr, wd);
        dir = 1'b1; nxt = 1'b1; data_in = 8'hC3;
        #1 chk(!oe, "R8 release on rise during command", oe, 0);
        tick();
        nxt = 1'b0; data_in = sb;
        tick();
        #1 chk(stat_valid && stat_data === sb, "R9 status during abort", stat_data, sb);
        dir = 1'b0; data_in = 8'h00;
        tick();
        #1 chk(oe && data_out === c, "R8 command re-driven", data_out, c);
        nxt = 1'b1; tick(); nxt = 1'b0;
        #1 chk(data_out === wd, "R8 retried write data", data_out, wd);
        tick();
        #1 chk(stp, "R8 retried stop", stp, 1);
        tick();
        back_idle();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        rst = 1'b1; dir = 1'b0; nxt = 1'b0; data_in = 8'h00;
        req_valid = 1'b0; req_kind = 2'd0; req_addr = 6'd0; req_wdata = 8'd0;
        repeat (3) tick();
        #1 chk(oe && data_out === 8'h00 && !stp, "R1 reset bus idle", {oe, stp, data_out}, {2'b10, 8'h00});
        chk(!rsp_valid && !stat_valid && !rx_valid, "R1 reset strobes", {rsp_valid, stat_valid, rx_valid}, 0);
        rst = 1'b0;
        tick();
        #1 chk(req_ready === 1'b1, "R1 ready after reset", req_ready, 1);

        // directed corners
        do_write(6'h3F, 8'hFF, 0);
        do_write(6'h00, 8'h01, 3);
        do_xmit(6'h2D, 0);
        do_read(6'h15, 8'hA5, 0, 8'hEE);
        rx_burst(1);
        do_abort(6'h0A, 8'h77, 8'h4C);

        // constrained random mix
        for (int it = 0; it < 80; it++) begin
            int op;
            op = $urandom_range(0, 4);
            case (op)
                0: do_write(6'($urandom_range(0, 63)), 8'($urandom_range(0, 255)), $urandom_range(0, 3));
                1: do_read(6'($urandom_range(0, 63)), 8'($urandom_range(0, 255)), $urandom_range(0, 3), 8'($urandom_range(1, 255)));
                2: do_xmit(6'($urandom_range(0, 63)), $urandom_range(0, 3));
                3: rx_burst($urandom_range(1, 6));
                default: do_abort(6'($urandom_range(0, 63)), 8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)));
            endcase
            repeat ($urandom_range(0, 2)) begin
                tick();
                back_idle();
            end
        end

        chk(bus_viol == 0, "R3 bus monitor", bus_viol, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule